// File: doc/BRIEF.md
# Serial Word Memory Command Slave

This block is the device side of a small serial memory that stores 16-bit words. A host reaches it through an active-low select, a serial clock, a serial data input and a serial data output with its own drive enable. A write-inhibit input and a ready output complete the interface. Every pin is brought into a fast system clock domain through a two-stage synchroniser. Edges of the serial clock and of the select are found by comparing each synchronised level with its value one system clock earlier. The register array resets to all ones.

Each transaction is a frame of 32 serial clocks, and the host must deselect between frames. The block decodes four commands: read, write, write-enable and write-disable. A read streams words out and moves on to the next address for as long as the host keeps clocking. A write needs the write-enable latch to be set. It then runs a self-timed program cycle, counted in system clocks, during which the ready output is low. The host can learn the ready state through the data output as well as through the ready pin. There is no valid/ready stream at this edge, because the serial pins carry their own framing, so no back-pressure rules apply. All pins are plain control and data.

Top module: `serial_mem_slave`

## Requirements
- R1: The data input is sampled on rising serial-clock edges. A frame is four start bits, then four opcode bits (both most significant bit first), then an 8-bit address and then 16 data bits. The address and the data are least significant bit first.
- R2: The start code is 1010. A frame with any other start code, or with an unknown opcode, has no effect, and the rest of the frame is ignored until select goes high.
- R3: The opcode 1000 is a read. From the falling serial-clock edge that ends the 16th clock, the output drives the addressed word least significant bit first, one bit per falling edge. Raising select ends the read at once.
- R4: If clocking continues during a read, the next higher address follows every 16 clocks. The address wraps from the top word to word 0.
- R5: The write-enable latch is clear after reset. Opcode 0011 sets it and opcode 0000 clears it, whatever the write-inhibit level. The change takes effect at the 16th rising edge. Later clocks in that selection are ignored.
- R6: Opcode 0100 is a write. It is accepted only when the latch is set and write-inhibit is low at the 32nd rising edge. A write that is not accepted changes no word, and ready stays high.
- R7: An accepted write drives ready low right after the 32nd rising edge, for PROG_CYCLES system clocks. Then the word is updated and ready returns high.
- R8: If write-inhibit is high during the program cycle, the cycle stops at once and ready returns high. This implementation then leaves the word at its old value.
- R9: A selection that starts while ready is low is ignored entirely. No command is decoded and the output is not driven.
- R10: After an accepted write, a select fall that sees the serial clock low drives the output with the ready state (0 busy, 1 ready). This lasts until the first rising edge or until deselect.
- R11: The output enable is low whenever select is high, and outside the read-data and status phases.
- R12: Every word reads 16'hFFFF after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low select |
| sck | input | 1 | Serial clock |
| sdi | input | 1 | Serial data in |
| wr_inhibit | input | 1 | High blocks or stops a write |
| sdo | output | 1 | Serial data out |
| sdo_en | output | 1 | Drive enable for sdo (low means high impedance) |
| rdy | output | 1 | High when no program cycle is running |

## Verification
The bench reads across the top of the array to catch an address counter that saturates instead of wrapping, or that skips a word at the 16-clock boundary. It sends a write-enable and then keeps clocking a full write frame without deselecting; a design that rearms its bit counter on its own would commit that write. It raises write-inhibit midway through a program cycle and expects ready back at once with the old word kept, which catches a timer that ignores the abort. It also opens a frame while busy and asks for status with the serial clock low, both before and after completion; a design that decodes during busy, or that reports a stale ready level, shows up on the data output.

// File: rtl/smem_pkg.sv
package smem_pkg;
  localparam int WORD_W  = 16;
  localparam int AFLD_W  = 8;
  localparam int CMD_W   = 8;
  localparam int CNT_W   = 6;
  localparam logic [3:0] START_CODE = 4'b1010;

  typedef enum logic [3:0] {
    OP_READ  = 4'b1000,
    OP_WRITE = 4'b0100,
    OP_WREN  = 4'b0011,
    OP_WRDIS = 4'b0000
  } op_e;

  typedef enum logic [2:0] {
    F_IDLE,
    F_HDR,
    F_WDAT,
    F_RDOUT,
    F_HOLD
  } fstate_e;
endpackage

// File: rtl/smem_sync.sv
module smem_sync #(
  parameter int N = 4,
  parameter logic [N-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  output logic [N-1:0] lvl
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic [1:0] sh;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= {2{INIT[i]}};
      else        sh <= {sh[0], din[i]};
    end
    assign lvl[i] = sh[1];
  end
endmodule

// File: rtl/smem_array.sv
module smem_array
  import smem_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int PROG_CYCLES = 2000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_data,
  input  logic              wr_go,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              abort_i,
  output logic              busy
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int TCNT_W = $clog2(PROG_CYCLES + 1);
  localparam logic [TCNT_W-1:0] TLAST = TCNT_W'(PROG_CYCLES - 1);

  logic [TCNT_W-1:0] tcnt;
  logic [ADDR_W-1:0] paddr;
  logic [WORD_W-1:0] pdata;
  logic              commit;
  logic [WORD_W-1:0] words [DEPTH];

  assign commit = busy && !abort_i && (tcnt == TLAST);

  // program timer: abort has priority over completion
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      tcnt  <= '0;
      paddr <= '0;
      pdata <= '0;
    end else if (wr_go && !busy) begin
      busy  <= 1'b1;
      tcnt  <= '0;
      paddr <= wr_addr;
      pdata <= wr_data;
    end else if (busy) begin
      if (abort_i || commit) busy <= 1'b0;
      else                   tcnt <= tcnt + 1'b1;
    end
  end

  for (genvar w = 0; w < DEPTH; w++) begin : g_word
    logic [WORD_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                     q <= '1;
      else if (commit && paddr == ADDR_W'(w))         q <= pdata;
    end
    assign words[w] = q;
  end

  assign rd_data = words[rd_addr];
endmodule

// File: rtl/smem_frame.sv
module smem_frame
  import smem_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_hi,
  input  logic              sck_lvl,
  input  logic              di,
  input  logic              wc_hi,
  input  logic              busy,
  input  logic [WORD_W-1:0] rd_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              wr_go,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [WORD_W-1:0] wr_data,
  output logic              sdo,
  output logic              sdo_en,
  output logic              wel,
  output logic              rd_act
);
  fstate_e           state;
  logic              cs_q, sck_q;
  logic [CNT_W-1:0]  bcnt;
  logic [CMD_W-1:0]  cmd;
  logic [AFLD_W-1:0] afld;
  logic [WORD_W-1:0] wsh;
  logic [WORD_W-1:0] rword;
  logic [3:0]        ridx;
  logic [ADDR_W-1:0] rptr;
  logic              sdo_r, stat_on, arm;

  logic cs_fall, sck_rise, sck_fall;
  logic [AFLD_W-1:0] afld_nx;
  logic [WORD_W-1:0] wsh_nx;

  assign cs_fall  = cs_q & ~cs_hi;
  assign sck_rise = sck_lvl & ~sck_q;
  assign sck_fall = ~sck_lvl & sck_q;
  assign afld_nx  = {di, afld[AFLD_W-1:1]};
  assign wsh_nx   = {di, wsh[WORD_W-1:1]};

  assign rd_addr = (state == F_RDOUT) ? rptr : afld_nx[ADDR_W-1:0];
  assign wr_addr = afld[ADDR_W-1:0];
  assign wr_data = wsh_nx;
  assign wr_go   = !cs_hi && (state == F_WDAT) && sck_rise &&
                   (bcnt == CNT_W'(31)) && wel && !wc_hi;

  assign sdo    = stat_on ? ~busy : sdo_r;
  assign sdo_en = stat_on | rd_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q  <= 1'b1;
      sck_q <= 1'b0;
    end else begin
      cs_q  <= cs_hi;
      sck_q <= sck_lvl;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= F_IDLE;
      bcnt    <= '0;
      cmd     <= '0;
      afld    <= '0;
      wsh     <= '0;
      rword   <= '0;
      ridx    <= '0;
      rptr    <= '0;
      sdo_r   <= 1'b0;
      stat_on <= 1'b0;
      arm     <= 1'b0;
      wel     <= 1'b0;
      rd_act  <= 1'b0;
    end else if (cs_hi) begin
      state   <= F_IDLE;
      bcnt    <= '0;
      rd_act  <= 1'b0;
      stat_on <= 1'b0;
    end else if (cs_fall) begin
      bcnt <= '0;
      if (arm && !sck_lvl) begin
        stat_on <= 1'b1;
        if (!busy) arm <= 1'b0;
      end
      state <= busy ? F_HOLD : F_HDR;
    end else begin
      if (sck_rise) stat_on <= 1'b0;
      unique case (state)
        F_HDR: if (sck_rise) begin
          bcnt <= bcnt + 1'b1;
          if (bcnt < CNT_W'(8)) cmd  <= {cmd[CMD_W-2:0], di};
          else                  afld <= afld_nx;
          if (bcnt == CNT_W'(15)) begin
            state <= F_HOLD;
            if (cmd[7:4] == START_CODE) begin
              case (cmd[3:0])
                OP_READ: begin
                  state <= F_RDOUT;
                  rword <= rd_data;
                  rptr  <= afld_nx[ADDR_W-1:0] + 1'b1;
                  ridx  <= '0;
                end
                OP_WRITE: state <= F_WDAT;
                OP_WREN:  wel <= 1'b1;
                OP_WRDIS: wel <= 1'b0;
                default:  ;
              endcase
            end
          end
        end
        F_WDAT: if (sck_rise) begin
          bcnt <= bcnt + 1'b1;
          wsh  <= wsh_nx;
          if (bcnt == CNT_W'(31)) begin
            state <= F_HOLD;
            if (wel && !wc_hi) arm <= 1'b1;
          end
        end
        F_RDOUT: if (sck_fall) begin
          rd_act <= 1'b1;
          sdo_r  <= rword[ridx];
          ridx   <= ridx + 1'b1;
          if (ridx == 4'd15) begin
            rword <= rd_data;
            rptr  <= rptr + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/serial_mem_slave.sv
module serial_mem_slave
  import smem_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int PROG_CYCLES = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic sdi,
  input  logic wr_inhibit,
  output logic sdo,
  output logic sdo_en,
  output logic rdy
);
  logic [3:0]        pins_s;
  logic              cs_s, sck_s, di_s, wc_s;
  logic              busy, wel, rd_act, wr_go;
  logic [ADDR_W-1:0] rd_addr, wr_addr;
  logic [WORD_W-1:0] rd_data, wr_data;

  smem_sync #(.N(4), .INIT(4'b0001)) u_sync (
    .clk (clk),
    .rst_n (rst_n),
    .din ({wr_inhibit, sdi, sck, cs_n}),
    .lvl (pins_s)
  );

  assign cs_s  = pins_s[0];
  assign sck_s = pins_s[1];
  assign di_s  = pins_s[2];
  assign wc_s  = pins_s[3];

  smem_frame #(.ADDR_W(ADDR_W)) u_frame (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_hi   (cs_s),
    .sck_lvl (sck_s),
    .di      (di_s),
    .wc_hi   (wc_s),
    .busy    (busy),
    .rd_data (rd_data),
    .rd_addr (rd_addr),
    .wr_go   (wr_go),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .sdo     (sdo),
    .sdo_en  (sdo_en),
    .wel     (wel),
    .rd_act  (rd_act)
  );

  smem_array #(.ADDR_W(ADDR_W), .PROG_CYCLES(PROG_CYCLES)) u_array (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .wr_go   (wr_go),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .abort_i (wc_s),
    .busy    (busy)
  );

  assign rdy = ~busy;
endmodule

// File: rtl/smem_chk.sv
module smem_chk #(
  parameter int PROG_CYCLES = 2000
) (
  input logic clk,
  input logic rst_n,
  input logic cs_hi,
  input logic sck_s,
  input logic wc_s,
  input logic busy,
  input logic wel,
  input logic rd_act,
  input logic sdo_en
);
  logic [31:0] bcyc;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    bcyc <= '0;
    else if (busy) bcyc <= bcyc + 1'b1;
    else           bcyc <= '0;
  end

  // R11: deselect turns the output driver off on the next cycle
  assert_oe_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cs_hi |=> !sdo_en);

  // R6: a program cycle starts only with the latch set and inhibit low
  assert_write_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(wel) && !$past(wc_s)));

  // R7: an uninterrupted program cycle lasts exactly PROG_CYCLES clocks
  assert_prog_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && !$past(wc_s)) |-> (bcyc == 32'(PROG_CYCLES)));

  // R9: no read output while a program cycle runs
  assert_no_read_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !rd_act);

  // R5: the latch only moves right after a serial clock rising edge
  assert_wel_on_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wel) |-> ($past(sck_s) && !$past(sck_s, 2)));
endmodule

bind serial_mem_slave smem_chk #(.PROG_CYCLES(PROG_CYCLES)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .cs_hi  (cs_s),
  .sck_s  (sck_s),
  .wc_s   (wc_s),
  .busy   (busy),
  .wel    (wel),
  .rd_act (rd_act),
  .sdo_en (sdo_en)
);

// File: tb/sim_serial_mem_slave.sv
`timescale 1ns/1ps
module sim_serial_mem_slave;
  localparam int PROG = 1500;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, sdi = 1'b0, wr_inhibit = 1'b0;
  logic sdo, sdo_en, rdy;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  logic [15:0] model [256];
  logic [15:0] exp_q [$];
  bit          mon_on = 1'b0;
  int          mon_bits = 0;
  logic [15:0] mon_word;
  string       mon_req = "";

  always #2.5 clk = ~clk;

  serial_mem_slave #(.ADDR_W(8), .PROG_CYCLES(PROG)) u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi),
    .wr_inhibit(wr_inhibit), .sdo(sdo), .sdo_en(sdo_en), .rdy(rdy)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sbit(input logic b);
    sdi = b; sck = 1'b0; tick(HALF);
    sck = 1'b1; tick(HALF);
    sck = 1'b0;
  endtask

  task automatic send_hdr(input logic [3:0] st, input logic [3:0] op, input logic [7:0] a);
    for (int i = 3; i >= 0; i--) sbit(st[i]);
    for (int i = 3; i >= 0; i--) sbit(op[i]);
    for (int i = 0; i < 8; i++)  sbit(a[i]);
  endtask

  task automatic cs_begin();
    sck = 1'b0; cs_n = 1'b0; tick(HALF);
  endtask

  task automatic cs_end();
    tick(HALF); cs_n = 1'b1; tick(2 * HALF);
  endtask

  task automatic wait_ready();
    for (int n = 0; n < 4 * PROG && !rdy; n++) tick(1);
  endtask

  task automatic do_cmd(input logic [3:0] op);
    cs_begin(); send_hdr(4'b1010, op, 8'h00); cs_end();
  endtask

  task automatic do_write(input logic [7:0] a, input logic [15:0] d, input bit accept,
                          input bit wait_done, input string req);
    cs_begin();
    send_hdr(4'b1010, 4'b0100, a);
    for (int i = 0; i < 16; i++) sbit(d[i]);
    chk(rdy == !accept, req, 32'(rdy), 32'(!accept));
    cs_end();
    if (accept) begin
      model[a] = d;
      if (wait_done) wait_ready();
    end
  endtask

  task automatic read_body(input logic [7:0] a, input int n, input string req);
    for (int w = 0; w < n; w++) exp_q.push_back(model[8'(a + w)]);
    mon_req = req; mon_bits = 0; mon_on = 1'b1;
    for (int i = 0; i < 16 * n; i++) sbit(1'b0);
    mon_on = 1'b0;
  endtask

  task automatic do_read(input logic [7:0] a, input int n, input string req);
    cs_begin();
    send_hdr(4'b1010, 4'b1000, a);
    read_body(a, n, req);
    cs_end();
    chk(exp_q.size() == 0, req, 32'(exp_q.size()), 0);
    chk(sdo_en == 1'b0, "R11 idle after read", 32'(sdo_en), 0);
  endtask

  // monitor: collects DO bits on rising SK and scores whole words
  always @(posedge sck) begin
    if (mon_on) begin
      mon_word[mon_bits[3:0]] = sdo_en ? sdo : 1'bx;
      mon_bits++;
      if (mon_bits == 16) begin
        mon_bits = 0;
        if (exp_q.size() == 0) chk(1'b0, mon_req, 32'(mon_word), 32'hDEAD);
        else begin
          logic [15:0] e;
          e = exp_q.pop_front();
          chk(mon_word === e, mon_req, 32'(mon_word), 32'(e));
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) model[i] = 16'hFFFF;
    tick(4); rst_n = 1'b1; tick(4);

    chk(rdy == 1'b1, "R7 reset ready", 32'(rdy), 1);
    chk(sdo_en == 1'b0, "R11 reset oe", 32'(sdo_en), 0);

    do_read(8'h03, 1, "R12 R3 reset word");
    do_write(8'h05, 16'hA5C3, 1'b0, 1'b1, "R5 R6 no latch");
    do_read(8'h05, 1, "R6 unchanged");

    do_cmd(4'b0011);
    do_write(8'h05, 16'hA5C3, 1'b1, 1'b0, "R7 busy after write");
    cs_n = 1'b0; tick(4);
    chk(sdo_en && sdo == 1'b0, "R10 status busy", {30'd0, sdo_en, sdo}, 32'h2);
    cs_n = 1'b1; tick(HALF);
    sck = 1'b1; tick(HALF); cs_n = 1'b0; tick(HALF);
    send_hdr(4'b1010, 4'b1000, 8'h05);
    for (int i = 0; i < 16; i++) sbit(1'b0);
    chk(sdo_en == 1'b0, "R9 frame while busy", 32'(sdo_en), 0);
    chk(rdy == 1'b0, "R7 still busy", 32'(rdy), 0);
    cs_n = 1'b1; tick(2 * HALF);
    wait_ready();
    chk(rdy == 1'b1, "R7 completes", 32'(rdy), 1);
    cs_n = 1'b0; tick(4);
    chk(sdo_en && sdo == 1'b1, "R10 status ready", {30'd0, sdo_en, sdo}, 32'h3);
    tick(HALF);
    send_hdr(4'b1010, 4'b1000, 8'h05);
    read_body(8'h05, 1, "R1 R10 read after status");
    cs_end();

    do_write(8'hFF, 16'h1234, 1'b1, 1'b1, "R7 write top");
    do_write(8'h00, 16'hBEEF, 1'b1, 1'b1, "R7 write zero");
    do_write(8'h01, 16'h0F0F, 1'b1, 1'b1, "R7 write one");
    do_read(8'hFE, 4, "R4 sequential wrap");

    wr_inhibit = 1'b1;
    do_write(8'h06, 16'h7777, 1'b0, 1'b1, "R6 inhibit high");
    wr_inhibit = 1'b0;
    do_read(8'h06, 1, "R6 inhibit unchanged");

    do_write(8'h10, 16'h5555, 1'b1, 1'b0, "R7 start for abort");
    model[8'h10] = 16'hFFFF;
    tick(20);
    chk(rdy == 1'b0, "R8 busy before abort", 32'(rdy), 0);
    wr_inhibit = 1'b1; tick(6);
    chk(rdy == 1'b1, "R8 abort ready", 32'(rdy), 1);
    wr_inhibit = 1'b0; tick(4);
    do_read(8'h10, 1, "R8 word kept");

    cs_begin();
    send_hdr(4'b1010, 4'b0011, 8'h00);
    send_hdr(4'b1010, 4'b0100, 8'h30);
    for (int i = 0; i < 16; i++) sbit(1'b1);
    chk(rdy == 1'b1, "R5 clocks after command ignored", 32'(rdy), 1);
    cs_end();
    do_read(8'h30, 1, "R5 no stray write");

    cs_begin();
    send_hdr(4'b1110, 4'b0100, 8'h31);
    for (int i = 0; i < 16; i++) sbit(1'b0);
    chk(rdy == 1'b1, "R2 bad start", 32'(rdy), 1);
    cs_end();
    do_read(8'h31, 1, "R2 no write");

    cs_begin();
    send_hdr(4'b1010, 4'b1000, 8'h05);
    for (int i = 0; i < 6; i++) sbit(1'b0);
    chk(sdo_en == 1'b1, "R3 driving during read", 32'(sdo_en), 1);
    cs_n = 1'b1; tick(4);
    chk(sdo_en == 1'b0, "R3 R11 cancel", 32'(sdo_en), 0);
    tick(2 * HALF);

    wr_inhibit = 1'b1;
    do_cmd(4'b0000);
    do_cmd(4'b0011);
    wr_inhibit = 1'b0;
    do_write(8'h41, 16'hC0DE, 1'b1, 1'b1, "R5 enable ignores inhibit");
    do_cmd(4'b0000);
    do_write(8'h40, 16'h1111, 1'b0, 1'b1, "R5 R6 after disable");
    do_read(8'h40, 2, "R5 disable result");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule